// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is an up-counter with two compare inputs that produces a pulse-width-modulated waveform and a periodic interrupt pulse. A single-cycle count strobe advances it. One compare input, the period value N, sets the point where the counter wraps back to zero. The other, the duty value M, sets the point where the waveform goes back to its inactive level. The waveform becomes active at each period match and returns to inactive at each duty match. The interrupt pulse marks only the period match.

Software, or a neighbouring block, programs N and M with 0 ≤ M < N ≤ 2^CNT_W−1. It selects the polarity and raises the enable bit. The first count strobe after enable is discarded, and the waveform stays inactive until the first period match. Dropping the enable bit returns the counter, the waveform and the interrupt to their idle state. The next enable goes through the same start-up sequence again. Compare values are used exactly as presented on every cycle. Settings outside the legal range have no defined result.

Top module: `dual_cmp_pwm_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count_val is 0, irq_pulse is 0, and pwm_out sits at its inactive level.
- R2: After tmr_en rises, the first cnt_tick is swallowed and count_val stays 0. The second cnt_tick makes count_val 1.
- R3: While enabled and past start-up, each cnt_tick adds exactly one to count_val, and count_val holds its value on cycles without cnt_tick.
- R4: A cnt_tick that arrives while count_val equals period_cmp sets count_val to 0 on the next cycle. On that same next cycle, irq_pulse is high for exactly one clock.
- R5: From enable until the first period match, pwm_out holds its inactive level.
- R6: A period match makes the waveform active. A cnt_tick while count_val equals duty_cmp makes it inactive again, without clearing the counter and without raising irq_pulse. The active phase therefore covers M+1 strobes.
- R7: Once running, period matches repeat every N+1 strobes.
- R8: pwm_out equals the internal active state XOR pol_hi. With pol_hi=0 the inactive level is 0; with pol_hi=1 the inactive level is 1 and the waveform is inverted.
- R9: With tmr_en low at a clock edge, the next cycle shows count_val 0, irq_pulse 0 and pwm_out inactive. The first-strobe mask is re-armed for the next enable.
- R10: irq_pulse is never high except in the cycle that follows a period match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_tick | input | 1 | Count strobe, one clock wide per count |
| tmr_en | input | 1 | Timer enable (1 = run, 0 = idle and clear) |
| pol_hi | input | 1 | Output polarity: 0 = inactive low, 1 = inactive high |
| period_cmp | input | CNT_W (8) | Period compare value N |
| duty_cmp | input | CNT_W (8) | Duty compare value M, below N |
| pwm_out | output | 1 | PWM waveform |
| irq_pulse | output | 1 | One-clock pulse after each period match |
| count_val | output | CNT_W (8) | Current counter value |

## Verification
All counter, waveform-state and interrupt results are registered. They are due on the clock edge that samples the strobe or the enable change, so they can be observed one clock after the input was driven. Polarity alone reaches pwm_out combinationally, in the same cycle. The bench drives inputs and then samples every output at the following falling edge. It compares them there against a reference model that it advanced over that same edge. Directed sequences count samples between interrupt pulses and count active samples, which pins down the period and duty lengths to the exact strobe.

// File: rtl/pwmt_pkg.sv
// Package: shared width default and a polarity helper for the PWM timer.
// Assumes: all timer modules take their counter width from here by default.
package pwmt_pkg;

    localparam int PWMT_CNT_W = 8;

    // Map the internal active flag to the pin level for a given polarity.
    function automatic logic apply_pol(input logic active, input logic inv);
        return active ^ inv;
    endfunction

endpackage

// File: rtl/pwmt_start_gate.sv
// Module: pwmt_start_gate
// Turns raw count strobes into qualified count steps. The first strobe after
// each enable is discarded. Assumes run is low whenever the timer is idle.
module pwmt_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic step
);

    logic mask_q;

    // Mask flag: armed in reset or while idle, cleared by the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            mask_q <= 1'b1;
        end else if (tick) begin
            mask_q <= 1'b0;
        end
    end

    // A step is a strobe that arrives while running and unmasked.
    always_comb begin
        step = run & tick & ~mask_q;
    end

    // R2: the strobe that clears the mask must not count.
    assert_first_tick_swallowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $fell(mask_q)) |-> !$past(step));

endmodule

// File: rtl/pwmt_counter.sv
// Module: pwmt_counter
// Up-counter with period and duty comparators. It clears on a period match
// and counts through a duty match. Assumes duty < period while running.
module pwmt_counter #(
    parameter int CNT_W = pwmt_pkg::PWMT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] count,
    output logic             period_hit,
    output logic             duty_hit
);

    logic [CNT_W-1:0] count_q;

    // Comparator outputs, qualified by a real count step.
    always_comb begin
        period_hit = step && (count_q == period);
        duty_hit   = step && (count_q == duty) && !period_hit;
    end

    // Counter register: cleared when idle or on period match, else steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count_q <= '0;
        end else if (period_hit) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R3: a non-wrapping step advances the count by exactly one.
    assert_step_increments_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && count_q != period) |=> count_q == CNT_W'($past(count_q) + 1'b1));

    // R4: a period match always returns the counter to zero.
    assert_period_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period_hit) |=> count_q == '0);

endmodule

// File: rtl/pwmt_out_stage.sv
// Module: pwmt_out_stage
// Holds the waveform's active flag and the interrupt pulse register, and
// applies output polarity. Assumes hits come only from qualified steps.
module pwmt_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic period_hit,
    input  logic duty_hit,
    input  logic pol_hi,
    output logic pwm_out,
    output logic irq_pulse
);

    logic active_q;
    logic irq_q;

    // Active flag: set by a period match, cleared by a duty match or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active_q <= 1'b0;
        end else if (period_hit) begin
            active_q <= 1'b1;
        end else if (duty_hit) begin
            active_q <= 1'b0;
        end
    end

    // Interrupt register: one clock after each period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= run & period_hit;
        end
    end

    // Pin level: the active flag passed through the polarity select.
    always_comb begin
        pwm_out = pwmt_pkg::apply_pol(active_q, pol_hi);
    end

    assign irq_pulse = irq_q;

    // R6: the waveform only turns active on a period match.
    assert_active_from_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(period_hit));

    // R10: the interrupt is only raised after a period match.
    assert_irq_after_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(period_hit));

endmodule

// File: rtl/dual_cmp_pwm_timer.sv
// Module: dual_cmp_pwm_timer (top)
// PWM timer with a period compare (wrap, activate, interrupt) and a duty
// compare (deactivate only). Assumes duty_cmp < period_cmp while enabled.
module dual_cmp_pwm_timer #(
    parameter int CNT_W = pwmt_pkg::PWMT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             tmr_en,
    input  logic             pol_hi,
    input  logic [CNT_W-1:0] period_cmp,
    input  logic [CNT_W-1:0] duty_cmp,
    output logic             pwm_out,
    output logic             irq_pulse,
    output logic [CNT_W-1:0] count_val
);

    logic step;
    logic period_hit;
    logic duty_hit;

    pwmt_start_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_en),
        .tick  (cnt_tick),
        .step  (step)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tmr_en),
        .step       (step),
        .period     (period_cmp),
        .duty       (duty_cmp),
        .count      (count_val),
        .period_hit (period_hit),
        .duty_hit   (duty_hit)
    );

    pwmt_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tmr_en),
        .period_hit (period_hit),
        .duty_hit   (duty_hit),
        .pol_hi     (pol_hi),
        .pwm_out    (pwm_out),
        .irq_pulse  (irq_pulse)
    );

    // R9: an idle edge leaves the counter at zero with no interrupt.
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> (count_val == '0 && !irq_pulse));

    // R3: without a strobe, the count does not move while enabled.
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !cnt_tick) |=> $stable(count_val));

    // R4: the interrupt pulse is one clock wide and lands on a zero count.
    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (count_val == '0) ##1 !irq_pulse);

endmodule

// File: tb/dual_cmp_pwm_timer_bench.sv
module dual_cmp_pwm_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       tmr_en = 1'b0;
    logic       pol_hi = 1'b0;
    logic [7:0] period_cmp = 8'd5;
    logic [7:0] duty_cmp = 8'd2;
    logic       pwm_out;
    logic       irq_pulse;
    logic [7:0] count_val;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    bit m_mask = 1;
    bit m_act = 0;
    bit m_irq = 0;

    always #10 clk = ~clk;

    dual_cmp_pwm_timer u_dual_cmp_pwm_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_tick   (cnt_tick),
        .tmr_en     (tmr_en),
        .pol_hi     (pol_hi),
        .period_cmp (period_cmp),
        .duty_cmp   (duty_cmp),
        .pwm_out    (pwm_out),
        .irq_pulse  (irq_pulse),
        .count_val  (count_val)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        if (!rst_n || !tmr_en) begin
            m_cnt = 0; m_mask = 1; m_act = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (cnt_tick) begin
                if (m_mask) m_mask = 0;
                else if (m_cnt == int'(period_cmp)) begin
                    m_cnt = 0; m_act = 1; m_irq = 1;
                end else begin
                    if (m_cnt == int'(duty_cmp)) m_act = 0;
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
        end
    endtask

    // Drive inputs, pass one edge, sample at the falling edge and compare.
    task automatic cyc(input bit r, input bit e, input bit t);
        rst_n = r; tmr_en = e; cnt_tick = t;
        model_edge();
        @(negedge clk);
        chk("R3", "count_val", int'(count_val), m_cnt);
        chk("R10", "irq_pulse", int'(irq_pulse), int'(m_irq));
        chk("R8", "pwm_out", int'(pwm_out), int'(m_act ^ pol_hi));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int hi;
        void'($urandom(32'h1234_5eed));
        cyc(0, 0, 0);
        cyc(0, 1, 1);
        // R1: reset state
        chk("R1", "count after reset", int'(count_val), 0);
        chk("R1", "irq after reset", int'(irq_pulse), 0);
        chk("R1", "pwm after reset", int'(pwm_out), 0);

        // R2: first strobe swallowed
        cyc(1, 1, 0);
        cyc(1, 1, 1);
        chk("R2", "count after masked strobe", int'(count_val), 0);
        cyc(1, 1, 1);
        chk("R2", "count after second strobe", int'(count_val), 1);
        cyc(1, 1, 0);
        chk("R3", "count holds without strobe", int'(count_val), 1);

        // R5: inactive until first period match (N=5)
        for (int i = 0; i < 4; i++) begin
            cyc(1, 1, 1);
            chk("R5", "pwm before first match", int'(pwm_out), 0);
        end
        chk("R5", "count reaches N", int'(count_val), 5);
        cyc(1, 1, 1);
        chk("R4", "count cleared on period", int'(count_val), 0);
        chk("R4", "irq on period", int'(irq_pulse), 1);
        chk("R6", "pwm active after period", int'(pwm_out), 1);

        // R6/R7: active samples and period length
        hi = 1;
        for (int i = 1; i <= 5; i++) begin
            cyc(1, 1, 1);
            if (pwm_out) hi++;
            chk("R7", "no irq inside period", int'(irq_pulse), 0);
            if (i == 3) chk("R6", "count continues past duty", int'(count_val), 3);
        end
        chk("R6", "active samples M+1", hi, 3);
        cyc(1, 1, 1);
        chk("R7", "irq after N+1 strobes", int'(irq_pulse), 1);
        cyc(1, 1, 0);
        chk("R4", "irq one clock wide", int'(irq_pulse), 0);

        // R8: polarity inverts the pin at once
        pol_hi = 1'b1;
        #1;
        chk("R8", "inverted active level", int'(pwm_out), 0);

        // R9: disable clears, mask re-armed
        cyc(1, 0, 1);
        chk("R9", "count after disable", int'(count_val), 0);
        chk("R9", "pwm inactive high after disable", int'(pwm_out), 1);
        chk("R9", "irq after disable", int'(irq_pulse), 0);
        cyc(1, 1, 1);
        chk("R9", "re-enable strobe masked", int'(count_val), 0);
        cyc(1, 1, 1);
        chk("R9", "counts after mask", int'(count_val), 1);
        cyc(1, 0, 0);

        // random segments; settings change only while idle
        for (int s = 0; s < 24; s++) begin
            int len;
            int pct;
            period_cmp = 8'(1 + $urandom % 255);
            duty_cmp = 8'($urandom % int'(period_cmp));
            if (s < 3) begin
                period_cmp = (s == 0) ? 8'd1 : 8'd255;
                duty_cmp = (s == 2) ? 8'd254 : 8'd0;
            end
            pol_hi = $urandom % 2;
            pct = 30 + $urandom % 71;
            len = 200 + $urandom % 500;
            cyc(1, 0, 0);
            for (int i = 0; i < len; i++) begin
                cyc(1, ($urandom % 100) != 0, ($urandom % 100) < pct);
            end
        end
        cyc(1, 0, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule